// File: doc/BRIEF.md
# Tag SRAM with Match Comparator

This block is a small synchronous memory meant to hold the tags of a cache. Address, write data and every control input are sampled on the rising clock edge. A cycle can be a read, a write to one or both 9-bit byte lanes, or a compare. In a compare cycle the addressed word is read with the data output disabled. The read word is then checked against a value captured from the input bus into an internal input register, and a single match flag results.

A static mode input picks flow-through timing (no output register) or pipelined timing (one extra output register) for both the read data and the match flag. Two active-low enables act without a clock edge: one gates the data output, the other gates the match output. The data bus is shown as a value plus a drive indication, which a pad driver turns into a three-state bus. Three chip selects of mixed polarity must all be active for a cycle to take effect.

Top module: `tagram_cmp`

## Requirements
- R1: A cycle is selected only when ce_a_n is 0, ce_b is 1 and ce_c_n is 0 at the clock edge. A cycle that is not selected writes nothing, loads no input register and drives no data.
- R2: In a selected cycle with gw_n at 0 and de at 1, both lanes at addr take din. bwe_n and bsel_n have no effect.
- R3: In a selected cycle with gw_n at 1, bwe_n at 0 and de at 1, lane i is written if and only if bsel_n[i] is 0. Lane 0 is bits 8:0 and lane 1 is bits 17:9. With no lane selected the word stays unchanged.
- R4: A selected cycle with gw_n, bwe_n at 1 and cmp at 0 is a read and leaves the array unchanged. Read data appears after the sampling edge when pipe_mode is 0, and after the following edge when pipe_mode is 1.
- R5: A selected cycle with cmp at 1 and no write request is a compare. dout_drive stays 0, and the match flag is 1 exactly when the stored word equals the input register.
- R6: The match flag follows the same latency as read data in both modes. It is 0 after read, write and idle cycles.
- R7: The input register loads din only in selected cycles with de at 1. A write with de at 0 leaves the array unchanged. A compare with de at 0 uses the value held from earlier.
- R8: oe_n at 1 forces dout_drive to 0 and dout to 0 at once, without waiting for a clock edge.
- R9: moe_n at 1 forces match_o to 0 at once, without waiting for a clock edge.
- R10: After a read, dout_drive falls one edge after a deselected cycle is sampled in flow-through mode, and two edges after it in pipelined mode.
- R11: During and after reset, dout_drive and match_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_mode | input | 1 | 1 = pipelined output, 0 = flow-through |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| bsel_n | input | 2 | Per-lane select, active low |
| cmp | input | 1 | Compare cycle request |
| de | input | 1 | Synchronous data enable |
| addr | input | 8 | Word address |
| din | input | 18 | Write or compare data |
| oe_n | input | 1 | Asynchronous data output enable, active low |
| moe_n | input | 1 | Asynchronous match output enable, active low |
| dout | output | 18 | Read data, 0 when not driven |
| dout_drive | output | 1 | Data bus driven this cycle |
| match_o | output | 1 | Compare result |

## Verification
The assertions assume that the reset is held for at least one edge and that pipe_mode changes only after an idle cycle, when the output register holds nothing. The bench changes pipe_mode only between rows, and every row ends with deselected cycles. Control and data inputs are driven on the falling edge only, so each value is stable across the sampling edge. The asynchronous enables are toggled only in the middle of a cycle, where they act combinationally.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

    // Cycle kind decoded at the sampling edge
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_CMP   = 2'd3
    } op_e;

endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_a_n,
    input  logic                       ce_b,
    input  logic                       ce_c_n,
    input  logic                       gw_n,
    input  logic                       bwe_n,
    input  logic [LANES-1:0]           bsel_n,
    input  logic                       cmp,
    input  logic                       de,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [LANES*LANE_W-1:0]    din,
    output logic [LANES-1:0]           lane_we,
    output op_e                        op_q,
    output logic [ADDR_W-1:0]          addr_q,
    output logic [LANES*LANE_W-1:0]    ref_q
);

    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] ref_v;
    } st_t;

    st_t              st_d, st_q;
    logic             sel;
    logic [LANES-1:0] we_d;

    always_comb begin
        sel         = !ce_a_n && ce_b && !ce_c_n;
        st_d        = st_q;
        we_d        = '0;
        st_d.addr   = addr;
        if (!sel) begin
            st_d.op = OP_IDLE;
        end else begin
            if (de) begin
                st_d.ref_v = din;
            end
            if (!gw_n) begin
                st_d.op = OP_WRITE;
                if (de) begin
                    we_d = '1;
                end
            end else if (!bwe_n) begin
                st_d.op = OP_WRITE;
                if (de) begin
                    we_d = ~bsel_n;
                end
            end else if (cmp) begin
                st_d.op = OP_CMP;
            end else begin
                st_d.op = OP_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.op    <= OP_IDLE;
            st_q.addr  <= '0;
            st_q.ref_v <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lane_we = we_d;
    assign op_q    = st_q.op;
    assign addr_q  = st_q.addr;
    assign ref_q   = st_q.ref_v;

    // R1: a deselected edge leaves no operation behind
    a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_a_n && ce_b && !ce_c_n) |=> (op_q == OP_IDLE));

    // R7: input register holds when data enable is low
    a_r7_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !de |=> $stable(ref_q));

endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         lane_we,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/tagram_out.sv
module tagram_out
    import tagram_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              oe_n,
    input  logic              moe_n,
    input  op_e               op_q,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [WORD_W-1:0] ref_q,
    output logic [WORD_W-1:0] dout,
    output logic              dout_drive,
    output logic              match_o
);

    typedef struct packed {
        logic              rd_vld;
        logic              match;
        logic [WORD_W-1:0] data;
    } st_t;

    st_t  st_d, st_q;
    logic eq;
    logic vld_sel;
    logic match_sel;
    logic [WORD_W-1:0] data_sel;

    always_comb begin
        eq          = (rd_word == ref_q);
        st_d.rd_vld = (op_q == OP_READ);
        st_d.match  = (op_q == OP_CMP) && eq;
        st_d.data   = rd_word;
        if (pipe_mode) begin
            vld_sel   = st_q.rd_vld;
            match_sel = st_q.match;
            data_sel  = st_q.data;
        end else begin
            vld_sel   = st_d.rd_vld;
            match_sel = st_d.match;
            data_sel  = st_d.data;
        end
        dout_drive = vld_sel && !oe_n;
        dout       = dout_drive ? data_sel : '0;
        match_o    = match_sel && !moe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a read reaches the output register one edge later
    a_r4_pipe_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_READ) |=> st_q.rd_vld);

    // R6: a matching compare reaches the match register one edge later
    a_r6_pipe_match: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_CMP && rd_word == ref_q) |=> st_q.match);

    // R6: match never follows a non-compare cycle
    a_r6_match_only_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q != OP_CMP) |=> !st_q.match);

    // R10: idle cycle empties the output register
    a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_IDLE) |=> !st_q.rd_vld);

endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp
    import tagram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pipe_mode,
    input  logic                       ce_a_n,
    input  logic                       ce_b,
    input  logic                       ce_c_n,
    input  logic                       gw_n,
    input  logic                       bwe_n,
    input  logic [LANES-1:0]           bsel_n,
    input  logic                       cmp,
    input  logic                       de,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [LANES*LANE_W-1:0]    din,
    input  logic                       oe_n,
    input  logic                       moe_n,
    output logic [LANES*LANE_W-1:0]    dout,
    output logic                       dout_drive,
    output logic                       match_o
);

    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  lane_we;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] ref_q;
    logic [WORD_W-1:0] rd_word;

    tagram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_a_n  (ce_a_n),
        .ce_b    (ce_b),
        .ce_c_n  (ce_c_n),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bsel_n  (bsel_n),
        .cmp     (cmp),
        .de      (de),
        .addr    (addr),
        .din     (din),
        .lane_we (lane_we),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .ref_q   (ref_q)
    );

    tagram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk     (clk),
        .lane_we (lane_we),
        .wr_addr (addr),
        .wr_data (din),
        .rd_addr (addr_q),
        .rd_word (rd_word)
    );

    tagram_out #(.WORD_W(WORD_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_mode  (pipe_mode),
        .oe_n       (oe_n),
        .moe_n      (moe_n),
        .op_q       (op_q),
        .rd_word    (rd_word),
        .ref_q      (ref_q),
        .dout       (dout),
        .dout_drive (dout_drive),
        .match_o    (match_o)
    );

    // R2: global write enables every lane
    a_r2_gw_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_a_n && ce_b && !ce_c_n && !gw_n && de) |-> (&lane_we));

    // R1: no lane written while deselected
    a_r1_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_a_n && ce_b && !ce_c_n) |-> (lane_we == '0));

    // R5: data bus never driven after a compare cycle
    a_r5_cmp_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_CMP && !pipe_mode) |-> !dout_drive);

endmodule

// File: tb/tagram_cmp_tb_top.sv
module tagram_cmp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pipe_mode = 1'b0;
    logic        ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [1:0]  bsel_n = 2'b11;
    logic        cmp = 1'b0, de = 1'b0;
    logic [7:0]  addr = '0;
    logic [17:0] din = '0;
    logic        oe_n = 1'b0, moe_n = 1'b0;
    logic [17:0] dout;
    logic        dout_drive;
    logic        match_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tagram_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .cmp(cmp), .de(de),
        .addr(addr), .din(din), .oe_n(oe_n), .moe_n(moe_n),
        .dout(dout), .dout_drive(dout_drive), .match_o(match_o)
    );

    // op codes of the bench: 0 idle, 1 write, 2 read, 3 compare
    typedef struct packed {
        logic        pipe;
        logic [1:0]  op;
        logic        gw;
        logic [1:0]  bsel;
        logic [7:0]  addr;
        logic [17:0] din;
        logic        exp_z;
        logic [17:0] exp_d;
        logic        exp_m;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 15;
    localparam row_t TBL [NROWS] = '{
        '{1'b0, 2'd1, 1'b1, 2'b00, 8'd5, 18'h2A5A5, 1'b1, 18'h0,     1'b0, 4'd2},  // R2
        '{1'b0, 2'd2, 1'b0, 2'b00, 8'd5, 18'h0,     1'b0, 18'h2A5A5, 1'b0, 4'd4},  // R4
        '{1'b0, 2'd1, 1'b0, 2'b01, 8'd5, 18'h00123, 1'b1, 18'h0,     1'b0, 4'd3},  // R3
        '{1'b0, 2'd2, 1'b0, 2'b00, 8'd5, 18'h0,     1'b0, 18'h2A523, 1'b0, 4'd3},  // R3
        '{1'b1, 2'd1, 1'b0, 2'b10, 8'd5, 18'h3FFFF, 1'b1, 18'h0,     1'b0, 4'd3},  // R3
        '{1'b1, 2'd2, 1'b0, 2'b00, 8'd5, 18'h0,     1'b0, 18'h3FF23, 1'b0, 4'd4},  // R4
        '{1'b1, 2'd1, 1'b1, 2'b00, 8'd9, 18'h15555, 1'b1, 18'h0,     1'b0, 4'd2},  // R2
        '{1'b1, 2'd2, 1'b0, 2'b00, 8'd9, 18'h0,     1'b0, 18'h15555, 1'b0, 4'd4},  // R4
        '{1'b0, 2'd1, 1'b0, 2'b00, 8'd5, 18'h0,     1'b1, 18'h0,     1'b0, 4'd3},  // R3
        '{1'b0, 2'd2, 1'b0, 2'b00, 8'd5, 18'h0,     1'b0, 18'h3FF23, 1'b0, 4'd3},  // R3
        '{1'b0, 2'd3, 1'b0, 2'b00, 8'd9, 18'h15555, 1'b1, 18'h0,     1'b1, 4'd5},  // R5
        '{1'b1, 2'd3, 1'b0, 2'b00, 8'd9, 18'h15554, 1'b1, 18'h0,     1'b0, 4'd5},  // R5
        '{1'b1, 2'd3, 1'b0, 2'b00, 8'd5, 18'h3FF23, 1'b1, 18'h0,     1'b1, 4'd6},  // R6
        '{1'b0, 2'd2, 1'b0, 2'b00, 8'd9, 18'h0,     1'b0, 18'h15555, 1'b0, 4'd6},  // R6
        '{1'b1, 2'd3, 1'b0, 2'b00, 8'd5, 18'h3FF22, 1'b1, 18'h0,     1'b0, 4'd6}   // R6
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit s, input bit d, input int op, input bit g,
                         input logic [1:0] bs, input logic [7:0] a, input logic [17:0] v);
        ce_a_n = 1'b0; ce_b = s; ce_c_n = 1'b0;
        de = d; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 2'b11; cmp = 1'b0;
        addr = a; din = v;
        case (op)
            1: if (g) gw_n = 1'b0; else begin bwe_n = 1'b0; bsel_n = ~bs; end
            3: cmp = 1'b1;
            default: ;
        endcase
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 0, 1'b0, 2'b00, 8'd0, 18'd0);
    endtask

    task automatic check_out(input bit ez, input logic [17:0] ed, input bit em, input string tag);
        if (ez) begin
            chk(dout_drive == 1'b0, tag, 32'(dout_drive), 32'd0);
        end else begin
            chk(dout_drive == 1'b1, tag, 32'(dout_drive), 32'd1);
            chk(dout == ed, tag, 32'(dout), 32'(ed));
        end
        chk(match_o == em, tag, 32'(match_o), 32'(em));
    endtask

    // One command, then idle; sample at the latency the mode gives
    task automatic run(input bit p, input bit d, input int op, input bit g, input logic [1:0] bs,
                       input logic [7:0] a, input logic [17:0] v,
                       input bit ez, input logic [17:0] ed, input bit em, input string tag);
        pipe_mode = p;
        drive(1'b1, d, op, g, bs, a, v);
        @(negedge clk);
        if (!p) check_out(ez, ed, em, tag);
        idle();
        @(negedge clk);
        if (p) check_out(ez, ed, em, tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (2) @(negedge clk);
        // R11: reset state
        chk(dout_drive == 1'b0, "R11", 32'(dout_drive), 32'd0);
        chk(match_o == 1'b0, "R11", 32'(match_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout_drive == 1'b0 && match_o == 1'b0, "R11", {dout_drive, match_o}, 32'd0);

        for (int i = 0; i < NROWS; i++) begin
            run(TBL[i].pipe, 1'b1, int'(TBL[i].op), TBL[i].gw, TBL[i].bsel, TBL[i].addr,
                TBL[i].din, TBL[i].exp_z, TBL[i].exp_d, TBL[i].exp_m,
                $sformatf("R%0d row %0d", TBL[i].req, i));
        end

        // R1: deselected write and read do nothing
        pipe_mode = 1'b0;
        drive(1'b0, 1'b1, 1, 1'b1, 2'b00, 8'd9, 18'h0);
        @(negedge clk);
        drive(1'b0, 1'b1, 2, 1'b0, 2'b00, 8'd9, 18'h0);
        @(negedge clk);
        chk(dout_drive == 1'b0, "R1 deselected read", 32'(dout_drive), 32'd0);
        idle();
        @(negedge clk);
        run(1'b0, 1'b1, 2, 1'b0, 2'b00, 8'd9, 18'h0, 1'b0, 18'h15555, 1'b0, "R1 after deselected write");

        // R7: write with data enable low keeps the word
        run(1'b0, 1'b0, 1, 1'b1, 2'b00, 8'd9, 18'h0, 1'b1, 18'h0, 1'b0, "R7 write de low");
        run(1'b0, 1'b1, 2, 1'b0, 2'b00, 8'd9, 18'h0, 1'b0, 18'h15555, 1'b0, "R7 read back");
        // R7: compare with de low uses held value
        run(1'b0, 1'b1, 3, 1'b0, 2'b00, 8'd9, 18'h15555, 1'b1, 18'h0, 1'b1, "R7 load compare");
        run(1'b0, 1'b0, 3, 1'b0, 2'b00, 8'd9, 18'h00000, 1'b1, 18'h0, 1'b1, "R7 held compare");
        run(1'b1, 1'b1, 3, 1'b0, 2'b00, 8'd9, 18'h00001, 1'b1, 18'h0, 1'b0, "R7 reload compare");
        run(1'b1, 1'b0, 3, 1'b0, 2'b00, 8'd9, 18'h15555, 1'b1, 18'h0, 1'b0, "R7 held mismatch");

        // R8: data output enable acts without a clock
        pipe_mode = 1'b0;
        drive(1'b1, 1'b1, 2, 1'b0, 2'b00, 8'd9, 18'h0);
        @(negedge clk);
        chk(dout_drive == 1'b1, "R8 enabled", 32'(dout_drive), 32'd1);
        oe_n = 1'b1; #1;
        chk(dout_drive == 1'b0, "R8 disabled", 32'(dout_drive), 32'd0);
        chk(dout == 18'd0, "R8 dout zero", 32'(dout), 32'd0);
        oe_n = 1'b0; #1;
        chk(dout == 18'h15555, "R8 re-enabled", 32'(dout), 32'h15555);
        idle();
        @(negedge clk);

        // R9: match output enable acts without a clock
        drive(1'b1, 1'b1, 3, 1'b0, 2'b00, 8'd9, 18'h15555);
        @(negedge clk);
        chk(match_o == 1'b1, "R9 enabled", 32'(match_o), 32'd1);
        moe_n = 1'b1; #1;
        chk(match_o == 1'b0, "R9 disabled", 32'(match_o), 32'd0);
        moe_n = 1'b0; #1;
        chk(match_o == 1'b1, "R9 re-enabled", 32'(match_o), 32'd1);
        idle();
        @(negedge clk);

        // R10: deselect release timing, flow-through
        drive(1'b1, 1'b1, 2, 1'b0, 2'b00, 8'd9, 18'h0);
        @(negedge clk);
        chk(dout_drive == 1'b1, "R10 flow read", 32'(dout_drive), 32'd1);
        idle();
        @(negedge clk);
        chk(dout_drive == 1'b0, "R10 flow one edge", 32'(dout_drive), 32'd0);
        // R10: pipelined
        pipe_mode = 1'b1;
        @(negedge clk);
        drive(1'b1, 1'b1, 2, 1'b0, 2'b00, 8'd9, 18'h0);
        @(negedge clk);
        chk(dout_drive == 1'b0, "R10 pipe not yet", 32'(dout_drive), 32'd0);
        idle();
        @(negedge clk);
        chk(dout_drive == 1'b1, "R10 pipe still driven", 32'(dout_drive), 32'd1);
        @(negedge clk);
        chk(dout_drive == 1'b0, "R10 pipe two edges", 32'(dout_drive), 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule